// File: doc/BRIEF.md
# Calendar Time Transfer Sequencer

This block drives a complete calendar-time read or set on a real-time-clock chip whose registers are four bits wide. It sits above a nibble register master, which owns the serial wire timing and carries out one 4-bit register read or write per request. The sequencer owns the chip-enable line, the handshake that waits for the chip's busy flag to clear, the order in which registers are visited, and the assembly of BCD bytes.

A read request returns seconds, minutes, hours, day, month and year as BCD bytes, plus the weekday as a single nibble. A set request takes the same fields and writes each one as a units nibble followed by a tens nibble. Every accepted request ends with exactly one completion pulse. An error flag rides on that pulse when the busy flag never cleared within the retry budget. Binary conversion and century handling belong to software above this block.

Top module: `rtc_xfer_seq`

## Requirements
- R1: After reset, `ce_o`, `nib_req_o`, `done_o` and `err_o` are low and every time output is zero.
- R2: Each handshake attempt takes place with `ce_o` high. It first writes value 0x4 (24-hour mode) to register address 0xE (control), then reads address 0xE.
- R3: When bit 0 of the control read is 1 (busy), `ce_o` goes low for exactly GUARD_CYCLES clock cycles, then the handshake restarts with a new control write. GUARD_CYCLES is GUARD_NS divided by CLK_NS, rounded up (70 by default).
- R4: A request makes at most MAX_RETRY+2 handshake attempts. If all of them see busy, the request completes with `err_o` = 1, no calendar register is accessed, and the time outputs keep their values. If busy clears on attempt MAX_RETRY+2, the transfer goes ahead normally.
- R5: After a handshake that is not busy, a read visits thirteen addresses in this order, all as reads: 0x0, 0x1, 0x2, 0x3, 0x4, 0x5, 0x8, 0x9, 0xA, 0xB, 0xC, 0xD, 0x6. For each field the units address comes first and the tens address follows.
- R6: Each read output byte is the tens nibble shifted left by 4, ORed with the units nibble. The field-to-address pairs are: seconds 0x0/0x1, minutes 0x2/0x3, hours 0x4/0x5, day 0x8/0x9, month 0xA/0xB, year 0xC/0xD. `wday_o` holds the nibble read from 0x6.
- R7: A set writes the same thirteen addresses in the same order. A units address receives bits 3:0 of its field, a tens address receives bits 7:4, and address 0x6 receives `set_wday_i`. A set leaves the read outputs unchanged.
- R8: After the last register access, `ce_o` drops and `done_o` rises after exactly GUARD_CYCLES cycles with `ce_o` low.
- R9: Each accepted request produces exactly one one-cycle `done_o` pulse. `err_o` is high only together with `done_o`.
- R10: A request that arrives while a transfer is in progress has no effect. When `rd_req_i` and `wr_req_i` are high in the same cycle, the read is performed.
- R11: Set values are captured in the cycle the request is accepted. Changing `set_*_i` during the transfer does not change what is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req_i | input | 1 | Start a time read (single-cycle pulse) |
| wr_req_i | input | 1 | Start a time set (single-cycle pulse) |
| set_sec_i | input | 8 | BCD seconds to write |
| set_min_i | input | 8 | BCD minutes to write |
| set_hour_i | input | 8 | BCD hours to write |
| set_day_i | input | 8 | BCD day of month to write |
| set_mon_i | input | 8 | BCD month to write |
| set_year_i | input | 8 | BCD year to write |
| set_wday_i | input | 4 | Weekday nibble to write |
| sec_o | output | 8 | BCD seconds read |
| min_o | output | 8 | BCD minutes read |
| hour_o | output | 8 | BCD hours read |
| day_o | output | 8 | BCD day read |
| mon_o | output | 8 | BCD month read |
| year_o | output | 8 | BCD year read |
| wday_o | output | 4 | Weekday nibble read |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Busy timeout, valid with done_o |
| ce_o | output | 1 | Chip-enable to the clock chip |
| nib_req_o | output | 1 | Request to the nibble master, held until acknowledged |
| nib_wr_o | output | 1 | 1 = nibble write, 0 = nibble read |
| nib_addr_o | output | 4 | Register address of the nibble access |
| nib_wdata_o | output | 4 | Nibble to write |
| nib_ack_i | input | 1 | One-cycle acknowledge from the nibble master |
| nib_rdata_i | input | 4 | Read nibble, valid with nib_ack_i |

## Verification
The assertions assume that the nibble master raises `nib_ack_i` only while `nib_req_o` is high, for one cycle per access, and that requests arrive as single-cycle pulses. The bench keeps within these assumptions with a behavioural nibble master that latches each request, acknowledges it a fixed two cycles later, and refuses to start a new access in its acknowledge cycle. It issues requests only as one-cycle pulses from the falling clock edge. The busy flag is produced by the master model from a count of control reads, so the random runs and the directed runs at the retry limit set exactly how many handshakes see busy.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HS_WR,
      ST_HS_RD,
      ST_XFER,
      ST_GRD_RETRY,
      ST_GRD_END,
      ST_DONE
   } seq_state_t;

   localparam int          N_FIELDS  = 7;
   localparam int          NUM_STEPS = 13;
   localparam logic [3:0]  CTRL_ADDR = 4'hE;
   localparam logic [3:0]  CTRL_24H  = 4'h4;
   localparam logic [3:0]  WDAY_ADDR = 4'h6;

   // nibble address of transfer step s; the weekday register sits between
   // hours and day, so steps past hours skip two addresses
   function automatic logic [3:0] step_addr(input logic [3:0] s);
      if (s < 4'd6)       return s;
      else if (s < 4'd12) return s + 4'd2;
      else                return WDAY_ADDR;
   endfunction

   // field slot 0..6 (sec,min,hour,day,mon,year,wday) of step s
   function automatic logic [2:0] step_field(input logic [3:0] s);
      return (s < 4'd12) ? s[3:1] : 3'd6;
   endfunction

   // 0 = units nibble, 1 = tens nibble
   function automatic logic step_half(input logic [3:0] s);
      return (s < 4'd12) ? s[0] : 1'b0;
   endfunction

endpackage

// File: rtl/rtc_guard_timer.sv
module rtc_guard_timer #(
   parameter  int CYCLES = 70,
   localparam int CW     = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic zero
);

   logic [CW-1:0] cnt_q;

   if (CYCLES < 1) begin : g_bad_cycles
      $error("rtc_guard_timer: CYCLES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (start)           cnt_q <= CW'(CYCLES - 1);
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // a new guard window only opens after the previous one has run out
   assert_guard_idle_at_start_R3: assert property (
      @(posedge clk) disable iff (!rst_n) start |-> zero);

endmodule

// File: rtl/rtc_retry_ctr.sv
module rtc_retry_ctr #(
   parameter  int MAX_RETRY = 100,
   localparam int LIMIT     = MAX_RETRY + 1,
   localparam int RW        = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic exceeded
);

   logic [RW-1:0] cnt_q;

   if (MAX_RETRY < 0) begin : g_bad_retry
      $error("rtc_retry_ctr: MAX_RETRY must not be negative");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr)   cnt_q <= '0;
      else if (inc)   cnt_q <= cnt_q + 1'b1;
   end

   assign exceeded = (cnt_q > RW'(MAX_RETRY));

   assert_retry_no_inc_past_limit_R4: assert property (
      @(posedge clk) disable iff (!rst_n) inc |-> !exceeded);

   assert_retry_bounded_R4: assert property (
      @(posedge clk) disable iff (!rst_n) cnt_q <= RW'(LIMIT));

endmodule

// File: rtl/rtc_field_bank.sv
module rtc_field_bank #(
   parameter  int NIB_W    = 4,
   parameter  int N_FIELDS = 7,
   localparam int FIW      = $clog2(N_FIELDS),
   localparam int FW       = 2 * NIB_W,
   localparam int FLAT_W   = N_FIELDS * FW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [FLAT_W-1:0] cap_flat,
   input  logic [FIW-1:0]    sel_field,
   input  logic              sel_half,
   input  logic              ld_en,
   input  logic [NIB_W-1:0]  ld_nib,
   output logic [NIB_W-1:0]  put_nib,
   output logic [FLAT_W-1:0] get_flat
);

   logic [1:0][NIB_W-1:0] cap_q [N_FIELDS];
   logic [1:0][NIB_W-1:0] get_q [N_FIELDS];

   for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cap_q[f] <= '0;
            get_q[f] <= '0;
         end else begin
            if (cap_en) cap_q[f] <= cap_flat[f*FW +: FW];
            if (ld_en && (sel_field == FIW'(f))) get_q[f][sel_half] <= ld_nib;
         end
      end
      assign get_flat[f*FW +: FW] = get_q[f];
   end

   always_comb begin
      put_nib = '0;
      for (int f = 0; f < N_FIELDS; f++) begin
         if (sel_field == FIW'(f)) put_nib = cap_q[f][sel_half];
      end
   end

   assert_field_in_range_R5: assert property (
      @(posedge clk) disable iff (!rst_n) ld_en |-> (int'(sel_field) < N_FIELDS));

endmodule

// File: rtl/rtc_xfer_seq.sv
module rtc_xfer_seq
   import rtc_seq_pkg::*;
#(
   parameter  int CLK_NS       = 10,
   parameter  int GUARD_NS     = 700,
   parameter  int MAX_RETRY    = 100,
   parameter  int NIB_W        = 4,
   localparam int FW           = 2 * NIB_W,
   localparam int GUARD_CYCLES = (GUARD_NS + CLK_NS - 1) / CLK_NS,
   localparam int FIW          = $clog2(N_FIELDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_req_i,
   input  logic             wr_req_i,
   input  logic [FW-1:0]    set_sec_i,
   input  logic [FW-1:0]    set_min_i,
   input  logic [FW-1:0]    set_hour_i,
   input  logic [FW-1:0]    set_day_i,
   input  logic [FW-1:0]    set_mon_i,
   input  logic [FW-1:0]    set_year_i,
   input  logic [NIB_W-1:0] set_wday_i,
   output logic [FW-1:0]    sec_o,
   output logic [FW-1:0]    min_o,
   output logic [FW-1:0]    hour_o,
   output logic [FW-1:0]    day_o,
   output logic [FW-1:0]    mon_o,
   output logic [FW-1:0]    year_o,
   output logic [NIB_W-1:0] wday_o,
   output logic             done_o,
   output logic             err_o,
   output logic             ce_o,
   output logic             nib_req_o,
   output logic             nib_wr_o,
   output logic [3:0]       nib_addr_o,
   output logic [NIB_W-1:0] nib_wdata_o,
   input  logic             nib_ack_i,
   input  logic [NIB_W-1:0] nib_rdata_i
);

   if (NIB_W < 4) begin : g_bad_nib
      $error("rtc_xfer_seq: NIB_W must be at least 4");
   end
   if (CLK_NS < 1 || GUARD_NS < 1) begin : g_bad_time
      $error("rtc_xfer_seq: CLK_NS and GUARD_NS must be positive");
   end

   seq_state_t        state_q, state_d;
   logic [3:0]        step_q;
   logic              op_wr_q;
   logic              err_q;
   logic              accept, busy_seen, last_step;
   logic              tmr_start, tmr_zero;
   logic              rc_clr, rc_inc, rc_exceeded;
   logic              ld_en;
   logic [NIB_W-1:0]  put_nib;
   logic [N_FIELDS*FW-1:0] cap_flat, get_flat;

   assign accept    = (state_q == ST_IDLE) && (rd_req_i || wr_req_i);
   assign busy_seen = nib_rdata_i[0];
   assign last_step = (step_q == 4'(NUM_STEPS - 1));

   // ---------------- state machine ----------------
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:      if (accept) state_d = ST_HS_WR;
         ST_HS_WR:     if (nib_ack_i) state_d = ST_HS_RD;
         ST_HS_RD:     if (nib_ack_i) state_d = busy_seen ? ST_GRD_RETRY : ST_XFER;
         ST_XFER:      if (nib_ack_i && last_step) state_d = ST_GRD_END;
         ST_GRD_RETRY: if (tmr_zero) state_d = rc_exceeded ? ST_DONE : ST_HS_WR;
         ST_GRD_END:   if (tmr_zero) state_d = ST_DONE;
         ST_DONE:      state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
         op_wr_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            op_wr_q <= wr_req_i && !rd_req_i;
            err_q   <= 1'b0;
         end
         if (state_q == ST_HS_RD && nib_ack_i) step_q <= '0;
         else if (state_q == ST_XFER && nib_ack_i && !last_step) step_q <= step_q + 4'd1;
         if (state_q == ST_GRD_RETRY && tmr_zero && rc_exceeded) err_q <= 1'b1;
      end
   end

   // ---------------- nibble master interface ----------------
   assign nib_req_o   = (state_q == ST_HS_WR) || (state_q == ST_HS_RD) || (state_q == ST_XFER);
   assign ce_o        = nib_req_o;
   assign nib_wr_o    = (state_q == ST_HS_WR) || (state_q == ST_XFER && op_wr_q);
   assign nib_addr_o  = (state_q == ST_XFER) ? step_addr(step_q) : CTRL_ADDR;
   assign nib_wdata_o = (state_q == ST_HS_WR) ? NIB_W'(CTRL_24H) : put_nib;

   assign done_o = (state_q == ST_DONE);
   assign err_o  = done_o && err_q;

   // ---------------- helpers ----------------
   assign tmr_start = (state_q == ST_HS_RD && nib_ack_i && busy_seen) ||
                      (state_q == ST_XFER && nib_ack_i && last_step);
   assign rc_clr    = accept;
   assign rc_inc    = (state_q == ST_GRD_RETRY) && tmr_zero && !rc_exceeded;
   assign ld_en     = (state_q == ST_XFER) && nib_ack_i && !op_wr_q;

   assign cap_flat = {{(FW-NIB_W){1'b0}}, set_wday_i, set_year_i, set_mon_i,
                      set_day_i, set_hour_i, set_min_i, set_sec_i};

   rtc_guard_timer #(.CYCLES(GUARD_CYCLES)) u_guard (
      .clk   (clk),
      .rst_n (rst_n),
      .start (tmr_start),
      .zero  (tmr_zero)
   );

   rtc_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_retry (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (rc_clr),
      .inc      (rc_inc),
      .exceeded (rc_exceeded)
   );

   rtc_field_bank #(.NIB_W(NIB_W), .N_FIELDS(N_FIELDS)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (accept),
      .cap_flat  (cap_flat),
      .sel_field (FIW'(step_field(step_q))),
      .sel_half  (step_half(step_q)),
      .ld_en     (ld_en),
      .ld_nib    (nib_rdata_i),
      .put_nib   (put_nib),
      .get_flat  (get_flat)
   );

   assign sec_o  = get_flat[0*FW +: FW];
   assign min_o  = get_flat[1*FW +: FW];
   assign hour_o = get_flat[2*FW +: FW];
   assign day_o  = get_flat[3*FW +: FW];
   assign mon_o  = get_flat[4*FW +: FW];
   assign year_o = get_flat[5*FW +: FW];
   assign wday_o = get_flat[6*FW +: NIB_W];

   // ---------------- assertions ----------------
   assert_req_under_ce_R2: assert property (
      @(posedge clk) disable iff (!rst_n) nib_req_o |-> ce_o);

   assert_req_held_stable_R5: assert property (
      @(posedge clk) disable iff (!rst_n)
      (nib_req_o && !nib_ack_i) |=> (nib_req_o && $stable(nib_addr_o) && $stable(nib_wr_o)));

   assert_ce_low_after_fall_R3: assert property (
      @(posedge clk) disable iff (!rst_n) $fell(ce_o) |=> !ce_o);

   assert_done_single_cycle_R9: assert property (
      @(posedge clk) disable iff (!rst_n) done_o |=> !done_o);

   assert_err_only_with_done_R9: assert property (
      @(posedge clk) disable iff (!rst_n) err_o |-> done_o);

   assert_done_with_ce_low_R8: assert property (
      @(posedge clk) disable iff (!rst_n) done_o |-> (!ce_o && !nib_req_o));

   assert_write_nibble_stable_R7: assert property (
      @(posedge clk) disable iff (!rst_n)
      (nib_req_o && nib_wr_o && !nib_ack_i) |=> $stable(nib_wdata_o));

endmodule

// File: tb/test_rtc_xfer_seq.sv
module test_rtc_xfer_seq;

   localparam int G         = 70;
   localparam int MAX_RETRY = 100;
   localparam int LOGN      = 8192;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_req = 1'b0, wr_req = 1'b0;
   logic [7:0] s_sec = '0, s_min = '0, s_hour = '0, s_day = '0, s_mon = '0, s_year = '0;
   logic [3:0] s_wday = '0;
   logic [7:0] sec_o, min_o, hour_o, day_o, mon_o, year_o;
   logic [3:0] wday_o;
   logic       done_o, err_o, ce_o, nib_req_o, nib_wr_o;
   logic [3:0] nib_addr_o, nib_wdata_o;
   logic       nib_ack = 1'b0;
   logic [3:0] nib_rdata = '0;

   always #5 clk = ~clk;

   rtc_xfer_seq i_rtc_xfer_seq (
      .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req), .wr_req_i(wr_req),
      .set_sec_i(s_sec), .set_min_i(s_min), .set_hour_i(s_hour), .set_day_i(s_day),
      .set_mon_i(s_mon), .set_year_i(s_year), .set_wday_i(s_wday),
      .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .day_o(day_o), .mon_o(mon_o),
      .year_o(year_o), .wday_o(wday_o), .done_o(done_o), .err_o(err_o), .ce_o(ce_o),
      .nib_req_o(nib_req_o), .nib_wr_o(nib_wr_o), .nib_addr_o(nib_addr_o),
      .nib_wdata_o(nib_wdata_o), .nib_ack_i(nib_ack), .nib_rdata_i(nib_rdata));

   // ---------------- nibble master model ----------------
   logic [3:0] mreg [16];
   logic [3:0] log_a [LOGN];
   logic       log_w [LOGN];
   logic [3:0] log_d [LOGN];
   int         log_n = 0;
   int         cr_n = 0;
   int         busy_until = 0;
   int         ce_viol = 0;
   logic       m_busy = 1'b0;
   int         m_cnt = 0;
   logic [3:0] ma, md;
   logic       mw;

   always @(posedge clk) begin
      nib_ack <= 1'b0;
      if (m_busy) begin
         if (m_cnt != 0) m_cnt <= m_cnt - 1;
         else begin
            m_busy  <= 1'b0;
            nib_ack <= 1'b1;
            if (log_n < LOGN) begin
               log_a[log_n] <= ma; log_w[log_n] <= mw; log_d[log_n] <= md;
            end
            log_n <= log_n + 1;
            if (mw) mreg[ma] <= md;
            else if (ma == 4'hE) begin
               nib_rdata <= {mreg[4'hE][3:1], (cr_n < busy_until)};
               cr_n <= cr_n + 1;
            end else nib_rdata <= mreg[ma];
         end
      end else if (rst_n && nib_req_o && !nib_ack) begin
         m_busy <= 1'b1; m_cnt <= 1;
         ma <= nib_addr_o; mw <= nib_wr_o; md <= nib_wdata_o;
         if (!ce_o) ce_viol <= ce_viol + 1;
      end
   end

   // ---------------- ce gap / done monitor ----------------
   int   low_run = 0, done_gap = -1, gap_bad = 0, gap_seen = 0, done_cnt = 0, cyc = 0;
   logic armed = 1'b0;
   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (done_o) begin done_cnt <= done_cnt + 1; done_gap <= low_run; end
      if (ce_o) begin
         if (armed) begin
            gap_seen <= gap_seen + 1;
            if (low_run != G) gap_bad <= gap_bad + 1;
         end
         armed <= 1'b0; low_run <= 0;
      end else begin
         low_run <= low_run + 1;
         if (done_o) armed <= 1'b0;
      end
      if (!ce_o && low_run == 0 && cyc > 0 && !done_o && nib_req_o == 1'b0 && prev_ce) armed <= 1'b1;
      prev_ce <= ce_o;
   end
   logic prev_ce = 1'b0;

   // ---------------- checking ----------------
   int n_chk = 0, n_bad = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (cyc > 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            finish_up();
         end
      end
   end

   function automatic logic [3:0] exp_addr(input int k);
      case (k)
         0: return 4'h0;  1: return 4'h1;  2: return 4'h2;  3: return 4'h3;
         4: return 4'h4;  5: return 4'h5;  6: return 4'h8;  7: return 4'h9;
         8: return 4'hA;  9: return 4'hB;  10: return 4'hC; 11: return 4'hD;
         default: return 4'h6;
      endcase
   endfunction

   function automatic logic [3:0] exp_wnib(input int k, input logic [7:0] f [6],
                                           input logic [3:0] wd);
      if (k == 12) return wd;
      return (k % 2 == 0) ? f[k/2][3:0] : f[k/2][7:4];
   endfunction

   logic [7:0] held_f [6];
   logic [3:0] held_wd;

   task automatic snap_set();
      held_f[0] = s_sec; held_f[1] = s_min; held_f[2] = s_hour;
      held_f[3] = s_day; held_f[4] = s_mon; held_f[5] = s_year; held_wd = s_wday;
   endtask

   task automatic do_xfer(input bit rd, input bit wr, input int busy_k,
                          input bit scramble, input bit poke,
                          output bit err, output int base);
      int d0, t;
      busy_until = cr_n + busy_k;
      base = log_n; d0 = done_cnt;
      @(negedge clk); rd_req = rd; wr_req = wr;
      @(negedge clk); rd_req = 0; wr_req = 0;
      if (scramble) begin
         s_sec = ~s_sec; s_min = ~s_min; s_hour = ~s_hour; s_day = ~s_day;
         s_mon = ~s_mon; s_year = ~s_year; s_wday = ~s_wday;
      end
      if (poke) begin
         repeat (8) @(negedge clk);
         rd_req = 1; wr_req = 1; @(negedge clk); rd_req = 0; wr_req = 0;
      end
      t = 0;
      while (!done_o && t < 30000) begin @(negedge clk); t++; end
      chk(done_o == 1'b1, "R9", "done seen", done_o, 1);
      err = err_o;
      @(negedge clk); @(negedge clk);
      chk(done_cnt == d0 + 1, "R9", "done pulse count", done_cnt - d0, 1);
      chk(done_gap == G, "R8", "ce low cycles before done", done_gap, G);
   endtask

   task automatic check_hs(input int base, input int attempts, input string tag);
      int bad = 0;
      for (int a = 0; a < attempts; a++) begin
         if (!(log_a[base+2*a] == 4'hE && log_w[base+2*a] && log_d[base+2*a] == 4'h4)) bad++;
         if (!(log_a[base+2*a+1] == 4'hE && !log_w[base+2*a+1])) bad++;
      end
      chk(bad == 0, tag, "handshake ops mismatched", bad, 0);
   endtask

   task automatic check_read(input int base, input int attempts);
      int p = base + 2*attempts, bad = 0;
      chk(log_n - base == 2*attempts + 13, "R5", "op count", log_n - base, 2*attempts + 13);
      for (int k = 0; k < 13; k++)
         if (log_a[p+k] != exp_addr(k) || log_w[p+k]) bad++;
      chk(bad == 0, "R5", "read address order mismatches", bad, 0);
      chk(sec_o  == {mreg[1], mreg[0]}, "R6", "sec",  sec_o,  {mreg[1], mreg[0]});
      chk(min_o  == {mreg[3], mreg[2]}, "R6", "min",  min_o,  {mreg[3], mreg[2]});
      chk(hour_o == {mreg[5], mreg[4]}, "R6", "hour", hour_o, {mreg[5], mreg[4]});
      chk(day_o  == {mreg[9], mreg[8]}, "R6", "day",  day_o,  {mreg[9], mreg[8]});
      chk(mon_o  == {mreg[11], mreg[10]}, "R6", "mon", mon_o, {mreg[11], mreg[10]});
      chk(year_o == {mreg[13], mreg[12]}, "R6", "year", year_o, {mreg[13], mreg[12]});
      chk(wday_o == mreg[6], "R6", "wday", wday_o, mreg[6]);
   endtask

   task automatic check_set(input int base, input int attempts);
      int p = base + 2*attempts, bad = 0;
      chk(log_n - base == 2*attempts + 13, "R7", "op count", log_n - base, 2*attempts + 13);
      for (int k = 0; k < 13; k++)
         if (log_a[p+k] != exp_addr(k) || !log_w[p+k] ||
             log_d[p+k] != exp_wnib(k, held_f, held_wd)) bad++;
      chk(bad == 0, "R7", "write order/data mismatches", bad, 0);
   endtask

   task automatic preload();
      for (int a = 0; a < 16; a++) if (a != 14) mreg[a] = 4'($urandom_range(0, 15));
   endtask

   task automatic rand_set();
      s_sec = 8'($urandom); s_min = 8'($urandom); s_hour = 8'($urandom);
      s_day = 8'($urandom); s_mon = 8'($urandom); s_year = 8'($urandom);
      s_wday = 4'($urandom);
   endtask

   logic [7:0] o_prev [6];
   logic [3:0] w_prev;
   task automatic snap_out();
      o_prev[0] = sec_o; o_prev[1] = min_o; o_prev[2] = hour_o;
      o_prev[3] = day_o; o_prev[4] = mon_o; o_prev[5] = year_o; w_prev = wday_o;
   endtask
   function automatic bit out_same();
      return o_prev[0] == sec_o && o_prev[1] == min_o && o_prev[2] == hour_o &&
             o_prev[3] == day_o && o_prev[4] == mon_o && o_prev[5] == year_o &&
             w_prev == wday_o;
   endfunction

   initial begin
      bit err;
      int base, gb0, gs0;
      void'($urandom(32'h0BAD5EED));
      for (int a = 0; a < 16; a++) mreg[a] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!ce_o && !nib_req_o && !done_o && !err_o, "R1", "control outputs in reset",
          {ce_o, nib_req_o, done_o, err_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({sec_o, min_o, hour_o, day_o, mon_o, year_o, wday_o} == '0, "R1", "time outputs after reset",
          {sec_o, min_o, hour_o, day_o, mon_o, year_o, wday_o}, 0);

      // directed read
      mreg[0] = 4'h9; mreg[1] = 4'h5; mreg[2] = 4'h3; mreg[3] = 4'h4; mreg[4] = 4'h3;
      mreg[5] = 4'h2; mreg[6] = 4'h6; mreg[8] = 4'h1; mreg[9] = 4'h3; mreg[10] = 4'h2;
      mreg[11] = 4'h1; mreg[12] = 4'h9; mreg[13] = 4'h9;
      do_xfer(1, 0, 0, 0, 0, err, base);
      chk(!err, "R4", "err on clean read", err, 0);
      check_hs(base, 1, "R2");
      check_read(base, 1);
      chk(ce_viol == 0, "R2", "accesses with ce low", ce_viol, 0);

      // directed set; read outputs must not move (R7), inputs scrambled after accept (R11)
      s_sec = 8'h59; s_min = 8'h01; s_hour = 8'h23; s_day = 8'h31; s_mon = 8'h12;
      s_year = 8'h00; s_wday = 4'h0;
      snap_set(); snap_out();
      do_xfer(0, 1, 0, 1, 0, err, base);
      check_hs(base, 1, "R2");
      check_set(base, 1);
      chk(out_same(), "R7", "read outputs disturbed by set", sec_o, o_prev[0]);
      chk(mreg[1] == 4'h5 && mreg[0] == 4'h9, "R11", "seconds nibbles after scramble",
          {mreg[1], mreg[0]}, 8'h59);

      // R10: request pokes during a set are ignored
      rand_set(); snap_set(); snap_out();
      do_xfer(0, 1, 0, 0, 1, err, base);
      check_set(base, 1);
      chk(out_same(), "R10", "read outputs after ignored poke", sec_o, o_prev[0]);

      // R10: simultaneous rd and wr performs a read
      preload(); rand_set();
      do_xfer(1, 1, 0, 0, 0, err, base);
      check_read(base, 1);

      // R3: a few busy handshakes, gaps exactly G
      gb0 = gap_bad; gs0 = gap_seen;
      preload();
      do_xfer(1, 0, 3, 0, 0, err, base);
      chk(!err, "R3", "err after 3 busy", err, 0);
      check_hs(base, 4, "R3");
      check_read(base, 4);
      chk(gap_seen - gs0 == 3, "R3", "retry ce gaps seen", gap_seen - gs0, 3);
      chk(gap_bad == gb0, "R3", "retry ce gaps not equal to guard", gap_bad - gb0, 0);

      // R4: busy on MAX_RETRY+1 handshakes still succeeds
      preload();
      do_xfer(1, 0, MAX_RETRY + 1, 0, 0, err, base);
      chk(!err, "R4", "err at limit", err, 0);
      check_read(base, MAX_RETRY + 2);

      // R4: busy on every handshake aborts with error
      snap_out();
      rand_set();
      do_xfer(0, 1, MAX_RETRY + 2, 0, 0, err, base);
      chk(err, "R4", "err after exhausted retries", err, 1);
      chk(log_n - base == 2*(MAX_RETRY + 2), "R4", "ops on abort", log_n - base, 2*(MAX_RETRY + 2));
      chk(out_same(), "R4", "outputs after abort", sec_o, o_prev[0]);
      busy_until = cr_n;

      // random mix
      for (int it = 0; it < 24; it++) begin
         int bk = $urandom_range(0, 2);
         if ($urandom_range(0, 1) == 0) begin
            preload();
            do_xfer(1, 0, bk, 0, 0, err, base);
            chk(!err, "R6", "random read err", err, 0);
            check_read(base, bk + 1);
         end else begin
            rand_set(); snap_set(); snap_out();
            do_xfer(0, 1, bk, 0, 0, err, base);
            chk(!err, "R7", "random set err", err, 0);
            check_set(base, bk + 1);
            chk(out_same(), "R7", "random set read outputs", sec_o, o_prev[0]);
         end
      end
      chk(ce_viol == 0, "R2", "accesses with ce low overall", ce_viol, 0);
      chk(gap_bad == 0, "R3", "total bad retry gaps", gap_bad, 0);
      finish_up();
   end

endmodule